// File: doc/BRIEF.md
# Soft Reset and Cause Controller

This block generates reset pulses for a four-processor system and remembers why the most recent ones happened. Software writes small registers to request a power-on reset for chosen processors, a whole-system reset, or an externally initiated reset for chosen processors. External event lines can also request resets: a watchdog expiry, two push buttons, a debug port, a remote monitor, seven agents that report fatal errors, and the load strobe of the clock synthesizer.

Every request becomes a fixed-width pulse on the per-processor power-on reset lines, the system reset line or the per-processor externally initiated reset lines. Two read-only cause registers keep a snapshot of the sources behind the newest power-on event and the newest externally initiated event. Both event types are edge triggered, so a source that is held active gives a single pulse.

Register port: `wr_en`, a 3-bit `addr` and an 8-bit `wdata` write in one cycle. `rdata` is a combinational 32-bit read of the register that `addr` selects.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After `rst_n` is released, the power-on cause register (address 4) reads 0x80, meaning power-up only. Every other register reads 0, and all reset outputs are low.
- R2: A write to address 2 with bits 0..3 set drives the matching `por_o` bits high for exactly 16 cycles, starting after the write edge. The register then reads 0 again. It reads back the active pulse bits while a pulse runs.
- R3: A write to address 2 with bit 4 set drives `sys_rst_o` and all four `por_o` bits. Whenever `sys_rst_o` is high, every `por_o` bit is high.
- R4: A write to address 3 with bits 0..3 set drives the matching `xir_o` bits high for exactly 16 cycles.
- R5: On each power-on event the power-on cause register is replaced with that event's sources. Events that arrive in the same cycle are OR-ed together. Bit map:
  - bits 0..3: software per-processor reset
  - bit 4: software system reset
  - bit 5: debug-port reset
  - bit 6: push button
  - bit 7: power-up
  - bits 8..14: fatal error from agents 0..6
  - bit 15: synthesizer update
  - bit 16: watchdog
  - bit 17: remote monitor
  
  Every source other than bits 0..3 also drives the system reset.
- R6: On each externally initiated event the cause register at address 5 is replaced with that event's sources. Bits 0..3 are software per-processor. Bit 4 is the debug port, which resets all processors. Bit 5 is the push button, which resets all processors.
- R7: With bit 0 of address 0 set, a watchdog rise causes a system reset with cause bit 16. With that bit clear, the watchdog input changes no output and no cause.
- R8: Bits 4..7 of address 1 mask the fatal-error lines of agents 0..3. A masked fatal error starts no pulse and sets no cause bit. Agents 4..6 cannot be masked.
- R9: Address 6 drives three synthesizer pins: bit 0 to the load pin, bit 1 to the data pin and bit 2 to the clock pin. With bit 7 also set, the cycle after load and bit 7 become high together starts a system reset with cause bit 15.
- R10: External events act on the rising edge. An input held high for many cycles gives one pulse.
- R11: Writes to addresses 4 and 5 are ignored. Address 7 reads 0. Reserved bits read 0.
- R12: A new event during an active pulse adds its targets to the active lines and restarts the 16-cycle width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 32 | Read data of addressed register |
| wdog_i | input | 1 | Watchdog expiry |
| dbg_por_i | input | 1 | Debug-port system reset request |
| dbg_xir_i | input | 1 | Debug-port all-processor externally initiated reset |
| btn_por_i | input | 1 | Push button, system reset |
| btn_xir_i | input | 1 | Push button, all-processor externally initiated reset |
| fatal_i | input | 7 | Fatal-error lines of agents 0..6 |
| rmon_i | input | 1 | Remote-monitor reset request |
| por_o | output | 4 | Per-processor power-on reset |
| sys_rst_o | output | 1 | Whole-system reset |
| xir_o | output | 4 | Per-processor externally initiated reset |
| synth_load_o | output | 1 | Synthesizer load pin |
| synth_data_o | output | 1 | Synthesizer data pin |
| synth_clk_o | output | 1 | Synthesizer clock pin |

## Verification
The assertions assume that every event input is synchronous to `clk` and stays low while `rst_n` is low. They also assume that a cause register changes only in a cycle that starts a pulse. The stimulus changes inputs only on the falling clock edge and keeps them low through reset. It leaves at least 20 cycles between independent events, so each pulse and cause value can be observed on its own. The only exception is the deliberate overlap that exercises the restart rule.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
package rcc_pkg;
    localparam int NCPU     = 4;
    localparam int NAGENT   = 7;
    localparam int ADDR_W   = 3;
    localparam int WDATA_W  = 8;
    localparam int RDATA_W  = 32;
    localparam int POR_CW   = 18;
    localparam int XIR_CW   = 6;
    localparam int MASK_LSB = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_WDACT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
    localparam logic [ADDR_W-1:0] A_SPOR   = 3'd2;
    localparam logic [ADDR_W-1:0] A_SXIR   = 3'd3;
    localparam logic [ADDR_W-1:0] A_PCAUSE = 3'd4;
    localparam logic [ADDR_W-1:0] A_XCAUSE = 3'd5;
    localparam logic [ADDR_W-1:0] A_SYNTH  = 3'd6;

    // positions in the edge-detected event vector
    localparam int EV_SYNTH = 0;
    localparam int EV_WDOG  = 1;
    localparam int EV_DBGP  = 2;
    localparam int EV_DBGX  = 3;
    localparam int EV_BTNP  = 4;
    localparam int EV_BTNX  = 5;
    localparam int EV_FATAL = 6;
    localparam int EV_RMON  = EV_FATAL + NAGENT;
    localparam int EV_W     = EV_RMON + 1;

    localparam logic [POR_CW-1:0] PCAUSE_PWRUP = 18'h00080;

    typedef struct packed {
        logic rst_on_load;
        logic sclk;
        logic sdata;
        logic load;
    } synth_ctl_t;

    typedef struct packed {
        logic              wd_act;
        logic [NCPU-1:0]   fe_mask;
        synth_ctl_t        synth;
        logic [POR_CW-1:0] por_cause;
        logic [XIR_CW-1:0] xir_cause;
    } ctl_state_t;
endpackage

// File: rtl/rcc_edge.sv
`timescale 1ns/1ps
module rcc_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/rcc_pulse.sv
`timescale 1ns/1ps
module rcc_pulse #(
    parameter int N     = 4,
    parameter int WIDTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig,
    output logic [N-1:0] act
);
    localparam int CW = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [N-1:0]  act;
        logic [CW-1:0] cnt;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (|trig) begin
            st_d.act = st_q.act | trig;
            st_d.cnt = CW'(WIDTH - 1);
        end else if (|st_q.act) begin
            if (st_q.cnt == '0) st_d.act = '0;
            else                st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act = st_q.act;
endmodule

// File: rtl/rst_cause_ctrl.sv
`timescale 1ns/1ps
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int PULSE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WDATA_W-1:0] wdata,
    output logic [RDATA_W-1:0] rdata,
    input  logic               wdog_i,
    input  logic               dbg_por_i,
    input  logic               dbg_xir_i,
    input  logic               btn_por_i,
    input  logic               btn_xir_i,
    input  logic [NAGENT-1:0]  fatal_i,
    input  logic               rmon_i,
    output logic [NCPU-1:0]    por_o,
    output logic               sys_rst_o,
    output logic [NCPU-1:0]    xir_o,
    output logic               synth_load_o,
    output logic               synth_data_o,
    output logic               synth_clk_o
);
    ctl_state_t        st_d, st_q;
    logic [EV_W-1:0]   ev_lvl, ev_rise;
    logic [NCPU-1:0]   sw_por, sw_xir;
    logic              sw_sys;
    logic [NAGENT-1:0] fe_ok;
    logic [POR_CW-1:0] por_new;
    logic [XIR_CW-1:0] xir_new;
    logic              por_all, xir_all;
    logic [NCPU:0]     por_trig, por_act;
    logic [NCPU-1:0]   xir_trig;
    logic [POR_CW-1:0] por_cause_w;
    logic [XIR_CW-1:0] xir_cause_w;

    assign ev_lvl = {rmon_i, fatal_i, btn_xir_i, btn_por_i, dbg_xir_i,
                     dbg_por_i, wdog_i, st_q.synth.load & st_q.synth.rst_on_load};

    rcc_edge #(.W(EV_W)) edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(ev_lvl), .rise(ev_rise)
    );

    always_comb begin
        st_d   = st_q;
        sw_por = '0;
        sw_sys = 1'b0;
        sw_xir = '0;
        if (wr_en) begin
            case (addr)
                A_WDACT: st_d.wd_act  = wdata[0];
                A_MASK:  st_d.fe_mask = wdata[MASK_LSB +: NCPU];
                A_SPOR: begin
                    sw_por = wdata[NCPU-1:0];
                    sw_sys = wdata[NCPU];
                end
                A_SXIR:  sw_xir = wdata[NCPU-1:0];
                A_SYNTH: begin
                    st_d.synth.rst_on_load = wdata[7];
                    st_d.synth.sclk        = wdata[2];
                    st_d.synth.sdata       = wdata[1];
                    st_d.synth.load        = wdata[0];
                end
                default: ;
            endcase
        end

        fe_ok   = ev_rise[EV_FATAL +: NAGENT] & ~{{(NAGENT-NCPU){1'b0}}, st_q.fe_mask};
        por_new = {ev_rise[EV_RMON], ev_rise[EV_WDOG] & st_q.wd_act, ev_rise[EV_SYNTH],
                   fe_ok, 1'b0, ev_rise[EV_BTNP], ev_rise[EV_DBGP], sw_sys, sw_por};
        xir_new = {ev_rise[EV_BTNX], ev_rise[EV_DBGX], sw_xir};

        por_all  = |por_new[POR_CW-1:NCPU];
        xir_all  = |xir_new[XIR_CW-1:NCPU];
        por_trig = {por_all, sw_por | {NCPU{por_all}}};
        xir_trig = sw_xir | {NCPU{xir_all}};

        if (|por_new) st_d.por_cause = por_new;
        if (|xir_new) st_d.xir_cause = xir_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.por_cause <= PCAUSE_PWRUP;
        end else begin
            st_q <= st_d;
        end
    end

    rcc_pulse #(.N(NCPU + 1), .WIDTH(PULSE_W)) por_pulse_i (
        .clk(clk), .rst_n(rst_n), .trig(por_trig), .act(por_act)
    );

    rcc_pulse #(.N(NCPU), .WIDTH(PULSE_W)) xir_pulse_i (
        .clk(clk), .rst_n(rst_n), .trig(xir_trig), .act(xir_o)
    );

    assign por_o        = por_act[NCPU-1:0];
    assign sys_rst_o    = por_act[NCPU];
    assign synth_load_o = st_q.synth.load;
    assign synth_data_o = st_q.synth.sdata;
    assign synth_clk_o  = st_q.synth.sclk;
    assign por_cause_w  = st_q.por_cause;
    assign xir_cause_w  = st_q.xir_cause;

    always_comb begin
        rdata = '0;
        case (addr)
            A_WDACT:  rdata[0] = st_q.wd_act;
            A_MASK:   rdata[MASK_LSB +: NCPU] = st_q.fe_mask;
            A_SPOR:   rdata[NCPU:0] = por_act;
            A_SXIR:   rdata[NCPU-1:0] = xir_o;
            A_PCAUSE: rdata[POR_CW-1:0] = por_cause_w;
            A_XCAUSE: rdata[XIR_CW-1:0] = xir_cause_w;
            A_SYNTH: begin
                rdata[7] = st_q.synth.rst_on_load;
                rdata[2] = st_q.synth.sclk;
                rdata[1] = st_q.synth.sdata;
                rdata[0] = st_q.synth.load;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rcc_checker.sv
`timescale 1ns/1ps
module rcc_checker
    import rcc_pkg::*;
#(
    parameter int PULSE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCPU-1:0]   por_o,
    input logic              sys_rst_o,
    input logic [NCPU-1:0]   xir_o,
    input logic [POR_CW-1:0] por_cause,
    input logic [XIR_CW-1:0] xir_cause
);
    localparam int RW = $clog2(PULSE_W + 2) + 1;
    localparam logic [RW-1:0] RMAX = '1;

    logic [RW-1:0] por_run_q, xir_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            por_run_q <= '0;
            xir_run_q <= '0;
        end else begin
            por_run_q <= (|por_o) ? ((por_run_q == RMAX) ? RMAX : por_run_q + 1'b1) : '0;
            xir_run_q <= (|xir_o) ? ((xir_run_q == RMAX) ? RMAX : xir_run_q + 1'b1) : '0;
        end
    end

    AST_SYS_DRIVES_ALL_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (&por_o));                                   // R3
    AST_POR_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|por_o) |-> (por_run_q >= RW'(PULSE_W)));            // R2
    AST_XIR_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|xir_o) |-> (xir_run_q >= RW'(PULSE_W)));            // R4
    AST_PCAUSE_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(por_cause) |-> (|por_o));                         // R5
    AST_XCAUSE_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(xir_cause) |-> (|xir_o));                         // R6
    AST_SYSRST_HAS_SYS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> (|por_cause[POR_CW-1:NCPU]));         // R5
endmodule

bind rst_cause_ctrl rcc_checker #(.PULSE_W(PULSE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .por_o(por_o), .sys_rst_o(sys_rst_o),
    .xir_o(xir_o), .por_cause(por_cause_w), .xir_cause(xir_cause_w)
);

// File: tb/rst_cause_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb_top;
    localparam int PW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [31:0] rdata;
    logic        wdog_i = 0, dbg_por_i = 0, dbg_xir_i = 0, btn_por_i = 0, btn_xir_i = 0, rmon_i = 0;
    logic [6:0]  fatal_i = '0;
    logic [3:0]  por_o, xir_o;
    logic        sys_rst_o, synth_load_o, synth_data_o, synth_clk_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rst_cause_ctrl #(.PULSE_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .wdog_i(wdog_i), .dbg_por_i(dbg_por_i), .dbg_xir_i(dbg_xir_i), .btn_por_i(btn_por_i),
        .btn_xir_i(btn_xir_i), .fatal_i(fatal_i), .rmon_i(rmon_i), .por_o(por_o),
        .sys_rst_o(sys_rst_o), .xir_o(xir_o), .synth_load_o(synth_load_o),
        .synth_data_o(synth_data_o), .synth_clk_o(synth_clk_o)
    );

    // event bits: 0 wdog, 1 dbg_por, 2 dbg_xir, 3 btn_por, 4 btn_xir, 5..11 fatal 0..6, 12 rmon
    typedef struct packed {
        logic        wr;
        logic [2:0]  a;
        logic [7:0]  d;
        logic [12:0] ev;
        logic [3:0]  e_por;
        logic        e_sys;
        logic [3:0]  e_xir;
        logic [17:0] e_pc;
        logic [5:0]  e_xc;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 8'h00, 13'h0001, 4'h0, 1'b0, 4'h0, 18'h00080, 6'h00}, // R7 ignored
        '{1'b1, 3'd0, 8'h01, 13'h0000, 4'h0, 1'b0, 4'h0, 18'h00080, 6'h00}, // R7 enable
        '{1'b0, 3'd0, 8'h00, 13'h0001, 4'hF, 1'b1, 4'h0, 18'h10000, 6'h00}, // R7 wdog
        '{1'b1, 3'd2, 8'h05, 13'h0000, 4'h5, 1'b0, 4'h0, 18'h00005, 6'h00}, // R2
        '{1'b1, 3'd2, 8'h10, 13'h0000, 4'hF, 1'b1, 4'h0, 18'h00010, 6'h00}, // R3
        '{1'b1, 3'd3, 8'h0A, 13'h0000, 4'h0, 1'b0, 4'hA, 18'h00010, 6'h0A}, // R4
        '{1'b0, 3'd0, 8'h00, 13'h0004, 4'h0, 1'b0, 4'hF, 18'h00010, 6'h10}, // R6 debug
        '{1'b0, 3'd0, 8'h00, 13'h0010, 4'h0, 1'b0, 4'hF, 18'h00010, 6'h20}, // R6 button
        '{1'b0, 3'd0, 8'h00, 13'h0002, 4'hF, 1'b1, 4'h0, 18'h00020, 6'h20}, // R5 debug
        '{1'b0, 3'd0, 8'h00, 13'h0008, 4'hF, 1'b1, 4'h0, 18'h00040, 6'h20}, // R5 button
        '{1'b0, 3'd0, 8'h00, 13'h1000, 4'hF, 1'b1, 4'h0, 18'h20000, 6'h20}, // R5 remote
        '{1'b0, 3'd0, 8'h00, 13'h0080, 4'hF, 1'b1, 4'h0, 18'h00400, 6'h20}, // R8 unmasked
        '{1'b1, 3'd1, 8'h40, 13'h0000, 4'h0, 1'b0, 4'h0, 18'h00400, 6'h20}, // R8 mask agent 2
        '{1'b0, 3'd0, 8'h00, 13'h0080, 4'h0, 1'b0, 4'h0, 18'h00400, 6'h20}, // R8 masked
        '{1'b0, 3'd0, 8'h00, 13'h0800, 4'hF, 1'b1, 4'h0, 18'h04000, 6'h20}, // R8 agent 6
        '{1'b0, 3'd0, 8'h00, 13'h00A0, 4'hF, 1'b1, 4'h0, 18'h00100, 6'h20}, // R8 mixed
        '{1'b1, 3'd4, 8'hFF, 13'h0000, 4'h0, 1'b0, 4'h0, 18'h00100, 6'h20}, // R11
        '{1'b1, 3'd5, 8'hFF, 13'h0000, 4'h0, 1'b0, 4'h0, 18'h00100, 6'h20}, // R11
        '{1'b1, 3'd2, 8'h02, 13'h0002, 4'hF, 1'b1, 4'h0, 18'h00022, 6'h20}  // R5 same cycle
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        wr_en = 1'b0;
        addr  = a;
        #1;
        v = rdata;
    endtask

    task automatic drive(input logic wr, input logic [2:0] a, input logic [7:0] d,
                         input logic [12:0] ev);
        @(negedge clk);
        wr_en = wr;
        addr  = a;
        wdata = d;
        {rmon_i, fatal_i, btn_xir_i, btn_por_i, dbg_xir_i, dbg_por_i, wdog_i} = ev;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        {rmon_i, fatal_i, btn_xir_i, btn_por_i, dbg_xir_i, dbg_por_i, wdog_i} = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n;
        int rises;
        logic prev;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 por_o", {28'd0, por_o}, 32'h0);
        chk("R1 sys_rst_o", {31'd0, sys_rst_o}, 32'h0);
        chk("R1 xir_o", {28'd0, xir_o}, 32'h0);
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            chk("R1 register", v, (a == 4) ? 32'h80 : 32'h0);
        end

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].a, VECS[i].d, VECS[i].ev);
            chk("R2/R3/R5/R7/R8 por_o", {28'd0, por_o}, {28'd0, VECS[i].e_por});
            chk("R3/R5 sys_rst_o", {31'd0, sys_rst_o}, {31'd0, VECS[i].e_sys});
            chk("R4/R6 xir_o", {28'd0, xir_o}, {28'd0, VECS[i].e_xir});
            rd(3'd4, v);
            chk("R5/R11 por cause", v, {14'd0, VECS[i].e_pc});
            rd(3'd5, v);
            chk("R6/R11 xir cause", v, {26'd0, VECS[i].e_xc});
            repeat (PW + 4) @(negedge clk);
        end

        // R2: pulse width and self-clear
        drive(1'b1, 3'd2, 8'h01, '0);
        chk("R2 single bit", {28'd0, por_o}, 32'h1);
        rd(3'd2, v);
        chk("R2 readback active", v, 32'h1);
        n = 0;
        while (por_o[0] && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R2 width", n, PW);
        rd(3'd2, v);
        chk("R2 self clear", v, 32'h0);
        repeat (4) @(negedge clk);

        // R12: restart during active pulse
        drive(1'b1, 3'd2, 8'h01, '0);
        repeat (7) @(negedge clk);
        drive(1'b1, 3'd2, 8'h02, '0);
        chk("R12 merged targets", {28'd0, por_o}, 32'h3);
        n = 0;
        while (por_o[0] && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R12 restarted width", n, PW);
        repeat (4) @(negedge clk);

        // R10: held input gives one pulse
        @(negedge clk);
        btn_por_i = 1'b1;
        rises = 0;
        prev  = 1'b0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (sys_rst_o && !prev) rises++;
            prev = sys_rst_o;
        end
        btn_por_i = 1'b0;
        chk("R10 one pulse for held input", rises, 1);
        chk("R10 pulse ended while held", {31'd0, sys_rst_o}, 32'h0);
        repeat (PW + 4) @(negedge clk);

        // R9: synthesizer load reset
        drive(1'b1, 3'd6, 8'h81, '0);
        chk("R9 load pin", {31'd0, synth_load_o}, 32'h1);
        chk("R9 no reset yet", {31'd0, sys_rst_o}, 32'h0);
        @(negedge clk);
        chk("R9 system reset", {31'd0, sys_rst_o}, 32'h1);
        chk("R9 all cpus", {28'd0, por_o}, 32'hF);
        rd(3'd4, v);
        chk("R9 cause bit 15", v, 32'h8000);
        repeat (PW + 4) @(negedge clk);
        drive(1'b1, 3'd6, 8'h06, '0);
        chk("R9 pins", {29'd0, synth_clk_o, synth_data_o, synth_load_o}, 32'h6);
        chk("R9 no reset on clear", {31'd0, sys_rst_o}, 32'h0);
        rd(3'd6, v);
        chk("R9 readback", v, 32'h06);

        // R11: reserved bits and unmapped address
        drive(1'b1, 3'd0, 8'hFF, '0);
        rd(3'd0, v);
        chk("R11 reserved bits zero", v, 32'h1);
        rd(3'd1, v);
        chk("R11 mask readback", v, 32'h40);
        rd(3'd7, v);
        chk("R11 unmapped", v, 32'h0);

        // R1: reset again restores power-up state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd4, v);
        chk("R1 power-up cause", v, 32'h80);
        rd(3'd0, v);
        chk("R1 action cleared", v, 32'h0);
        rd(3'd1, v);
        chk("R1 mask cleared", v, 32'h0);
        rd(3'd6, v);
        chk("R1 synth cleared", v, 32'h0);

        finish_run();
    end
endmodule